// File: doc/BRIEF.md
# Linear Burst Controller for Pipelined Synchronous SRAM

This block drives a pipelined synchronous burst SRAM. It turns one linear request into one memory access per clock. The request carries a start word address, a word count, a direction and a byte-enable mask. The memory advances its own two-bit burst counter on every selected cycle that has no address strobe, and that counter rolls over inside an aligned group of four words. To keep a linear transfer from folding back inside such a group, the controller strobes a fresh address at the first word and again at every word that opens a new group.

Write data is pulled from the requester one word per clock through a request pulse. The word, its own byte mask and the write enable reach the memory pins together in the next cycle. Read data comes back two clocks after the memory registers the address. The controller captures it and hands it to the requester with a valid flag. A read burst ends with a deselect cycle, and the block stays busy until the last read word has been returned.

Top module: `sbsram_burst_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `mem_cs`, `mem_astb`, `mem_we`, `mem_oe`, `mem_dq_oe`, `rd_valid` and `busy` are 0, and `mem_be` is all zero.
- R2: A start request with a word count of zero is ignored. `busy` stays 0 and no memory cycle is issued.
- R3: `mem_astb` is 1 on the first word of a transfer and on every later word whose word address has its two low bits equal to 00. It is 0 on every other word cycle, so a transfer that starts at word 7 strobes again at word 8.
- R4: On word cycles with `mem_astb` at 0, `mem_addr` keeps the most recently strobed word address.
- R5: During a write, `wr_req` is 1 for one cycle per word. The `wr_data` and `wr_be` presented in that cycle appear on `mem_dq_o` and `mem_be` in the next cycle, together with `mem_cs`, `mem_we` and `mem_dq_oe`. Exactly one word is issued per clock and the count matches the request.
- R6: For each read word on the pins, `rd_valid` is 1 exactly three cycles later. `rd_data` then holds the memory word at the linear address, and words return in request order.
- R7: The cycle after the last read word of a burst is a deselect cycle: `mem_cs` is 0 and `mem_astb` is 1. Write bursts end without one.
- R8: `mem_oe` is never 1 together with `mem_we`. It is 1 on every read word cycle and in the cycle before each `rd_valid`.
- R9: `busy` goes to 1 on acceptance and falls in the same cycle as the last `rd_valid` of a read. Start requests made while `busy` is 1 are ignored.
- R10: Every read word carries the request's byte-enable mask on `mem_be`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Start pulse for a transfer |
| req_addr | input | AW | First word address |
| req_len | input | LW | Number of words |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | DW/8 | Byte mask applied to read words |
| wr_req | output | 1 | Requester must present the next write word this cycle |
| wr_data | input | DW | Write word |
| wr_be | input | DW/8 | Byte mask of this write word |
| busy | output | 1 | Transfer or read return in progress |
| rd_valid | output | 1 | `rd_data` holds a returned word |
| rd_data | output | DW | Returned read word |
| mem_cs | output | 1 | Memory select (active high) |
| mem_astb | output | 1 | Address strobe (active high) |
| mem_addr | output | AW | Word address to memory |
| mem_be | output | DW/8 | Byte enables to memory (active high) |
| mem_we | output | 1 | Write enable (active high) |
| mem_oe | output | 1 | Memory output enable (active high) |
| mem_dq_o | output | DW | Write data to memory |
| mem_dq_oe | output | 1 | Controller drives the data bus |
| mem_dq_i | input | DW | Data bus from memory |

## Verification
A wrong boundary decision in the sequencer shows within one cycle as a missing or extra `mem_astb`. It then corrupts a write-then-read pattern whose words all differ, because the memory folds the access back inside its four-word group. A word or remaining-count register that is off by one changes the number of `wr_req` pulses or read words, which the end of that same transfer exposes. A wrong read pipeline depth moves `rd_valid` away from the three-cycle offset on the first returned word, and a bad enable window shows as `mem_oe` low on a read or high on a write in the cycle it happens.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_RUN   = 2'd1,
      SEQ_DESEL = 2'd2
   } seq_state_e;

   // A word opens a new burst group when its low group bits are all zero.
   function automatic logic opens_group(input logic [7:0] low, input int unsigned nbits);
      logic [7:0] mask;
      mask = 8'((9'd1 << nbits) - 9'd1);
      return (low & mask) == 8'd0;
   endfunction

endpackage

// File: rtl/sbs_seq.sv
module sbs_seq
   import sbs_pkg::*;
#(
   parameter int AW         = 20,
   parameter int LW         = 8,
   parameter int BW         = 4,
   parameter int BURST_BITS = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_start,
   input  logic [AW-1:0] req_addr,
   input  logic [LW-1:0] req_len,
   input  logic          req_write,
   input  logic [BW-1:0] req_be,
   input  logic          drain_busy,
   output logic          iss_valid,
   output logic          iss_write,
   output logic          iss_strobe,
   output logic [AW-1:0] iss_addr,
   output logic [BW-1:0] iss_be,
   output logic          desel,
   output logic          seq_busy
);

   seq_state_e    state_q;
   logic [AW-1:0] addr_q;
   logic [LW-1:0] remain_q;
   logic          first_q;
   logic          write_q;
   logic [BW-1:0] be_q;
   logic          accept;
   logic          last_word;
   logic [7:0]    low_bits;

   assign accept    = req_start && (state_q == SEQ_IDLE) && !drain_busy && (req_len != '0);
   assign last_word = (remain_q == LW'(1));

   generate
      if (AW >= 8) begin : g_low_wide
         assign low_bits = addr_q[7:0];
      end else begin : g_low_narrow
         assign low_bits = 8'(addr_q);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= SEQ_IDLE;
         addr_q   <= '0;
         remain_q <= '0;
         first_q  <= 1'b0;
         write_q  <= 1'b0;
         be_q     <= '0;
      end else begin
         case (state_q)
            SEQ_IDLE: begin
               if (accept) begin
                  state_q  <= SEQ_RUN;
                  addr_q   <= req_addr;
                  remain_q <= req_len;
                  first_q  <= 1'b1;
                  write_q  <= req_write;
                  be_q     <= req_be;
               end
            end
            SEQ_RUN: begin
               addr_q   <= addr_q + AW'(1);
               remain_q <= remain_q - LW'(1);
               first_q  <= 1'b0;
               if (last_word) begin
                  state_q <= write_q ? SEQ_IDLE : SEQ_DESEL;
               end
            end
            SEQ_DESEL: state_q <= SEQ_IDLE;
            default:   state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign iss_valid  = (state_q == SEQ_RUN);
   assign iss_write  = write_q;
   assign iss_strobe = first_q || opens_group(low_bits, BURST_BITS);
   assign iss_addr   = addr_q;
   assign iss_be     = be_q;
   assign desel      = (state_q == SEQ_DESEL);
   assign seq_busy   = (state_q != SEQ_IDLE);

endmodule

// File: rtl/sbs_pins.sv
module sbs_pins #(
   parameter int AW = 20,
   parameter int DW = 32,
   parameter int BW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          iss_valid,
   input  logic          iss_write,
   input  logic          iss_strobe,
   input  logic [AW-1:0] iss_addr,
   input  logic [BW-1:0] iss_be,
   input  logic          desel,
   input  logic [DW-1:0] wr_data,
   input  logic [BW-1:0] wr_be,
   output logic          mem_cs,
   output logic          mem_astb,
   output logic [AW-1:0] mem_addr,
   output logic [BW-1:0] mem_be,
   output logic          mem_we,
   output logic [DW-1:0] mem_dq_o,
   output logic          mem_dq_oe
);

   logic wr_word;
   assign wr_word = iss_valid && iss_write;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_cs    <= 1'b0;
         mem_astb  <= 1'b0;
         mem_addr  <= '0;
         mem_be    <= '0;
         mem_we    <= 1'b0;
         mem_dq_o  <= '0;
         mem_dq_oe <= 1'b0;
      end else begin
         mem_cs    <= iss_valid;
         mem_astb  <= iss_valid ? iss_strobe : desel;
         mem_we    <= wr_word;
         mem_dq_oe <= wr_word;
         if (iss_valid && iss_strobe) mem_addr <= iss_addr;
         if (!iss_valid)   mem_be <= '0;
         else if (iss_write) mem_be <= wr_be;
         else              mem_be <= iss_be;
         if (wr_word) mem_dq_o <= wr_data;
      end
   end

endmodule

// File: rtl/sbs_rdpipe.sv
module sbs_rdpipe #(
   parameter int DW     = 32,
   parameter int RD_LAT = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_now,
   input  logic          rd_word,
   input  logic [DW-1:0] dq_i,
   output logic          rd_valid,
   output logic [DW-1:0] rd_data,
   output logic          oe,
   output logic          pend
);

   logic [RD_LAT-1:0] stg_q;
   logic              oe_next;

   generate
      for (genvar i = 0; i < RD_LAT; i++) begin : g_stage
         if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
               if (!rst_n) stg_q[0] <= 1'b0;
               else        stg_q[0] <= rd_word;
            end
         end else begin : g_body
            always_ff @(posedge clk) begin
               if (!rst_n) stg_q[i] <= 1'b0;
               else        stg_q[i] <= stg_q[i-1];
            end
         end
      end
   endgenerate

   // Enable covers the issue cycle through the cycle the last word sits on the bus.
   assign oe_next = rd_now || rd_word || (|stg_q[RD_LAT-2:0]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
         oe       <= 1'b0;
      end else begin
         rd_valid <= stg_q[RD_LAT-1];
         oe       <= oe_next;
         if (stg_q[RD_LAT-1]) rd_data <= dq_i;
      end
   end

   assign pend = |stg_q;

endmodule

// File: rtl/sbsram_burst_ctrl.sv
module sbsram_burst_ctrl
   import sbs_pkg::*;
#(
   parameter int AW          = 20,
   parameter int DW          = 32,
   parameter int LW          = 8,
   parameter int RD_LAT      = 2,
   parameter int BURST_WORDS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_start,
   input  logic [AW-1:0]     req_addr,
   input  logic [LW-1:0]     req_len,
   input  logic              req_write,
   input  logic [DW/8-1:0]   req_be,
   output logic              wr_req,
   input  logic [DW-1:0]     wr_data,
   input  logic [DW/8-1:0]   wr_be,
   output logic              busy,
   output logic              rd_valid,
   output logic [DW-1:0]     rd_data,
   output logic              mem_cs,
   output logic              mem_astb,
   output logic [AW-1:0]     mem_addr,
   output logic [DW/8-1:0]   mem_be,
   output logic              mem_we,
   output logic              mem_oe,
   output logic [DW-1:0]     mem_dq_o,
   output logic              mem_dq_oe,
   input  logic [DW-1:0]     mem_dq_i
);

   localparam int BW         = DW / 8;
   localparam int BURST_BITS = $clog2(BURST_WORDS);

   generate
      if (DW % 8 != 0) begin : g_bad_dw
         $error("DW must be a multiple of 8");
      end
      if (RD_LAT < 2) begin : g_bad_lat
         $error("RD_LAT must be at least 2");
      end
      if (BURST_WORDS < 2 || (1 << BURST_BITS) != BURST_WORDS || BURST_BITS > 8) begin : g_bad_burst
         $error("BURST_WORDS must be a power of two from 2 to 256");
      end
      if (AW < BURST_BITS || LW < 1) begin : g_bad_width
         $error("AW or LW too small");
      end
   endgenerate

   logic          iss_valid;
   logic          iss_write;
   logic          iss_strobe;
   logic [AW-1:0] iss_addr;
   logic [BW-1:0] iss_be;
   logic          desel;
   logic          seq_busy;
   logic          drain_busy;
   logic          pin_rd_word;
   logic          rd_pend;

   assign pin_rd_word = mem_cs && !mem_we;
   assign drain_busy  = rd_pend || pin_rd_word || mem_oe;
   assign busy        = seq_busy || drain_busy;
   assign wr_req      = iss_valid && iss_write;

   sbs_seq #(
      .AW(AW), .LW(LW), .BW(BW), .BURST_BITS(BURST_BITS)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_start  (req_start),
      .req_addr   (req_addr),
      .req_len    (req_len),
      .req_write  (req_write),
      .req_be     (req_be),
      .drain_busy (drain_busy),
      .iss_valid  (iss_valid),
      .iss_write  (iss_write),
      .iss_strobe (iss_strobe),
      .iss_addr   (iss_addr),
      .iss_be     (iss_be),
      .desel      (desel),
      .seq_busy   (seq_busy)
   );

   sbs_pins #(
      .AW(AW), .DW(DW), .BW(BW)
   ) u_pins (
      .clk        (clk),
      .rst_n      (rst_n),
      .iss_valid  (iss_valid),
      .iss_write  (iss_write),
      .iss_strobe (iss_strobe),
      .iss_addr   (iss_addr),
      .iss_be     (iss_be),
      .desel      (desel),
      .wr_data    (wr_data),
      .wr_be      (wr_be),
      .mem_cs     (mem_cs),
      .mem_astb   (mem_astb),
      .mem_addr   (mem_addr),
      .mem_be     (mem_be),
      .mem_we     (mem_we),
      .mem_dq_o   (mem_dq_o),
      .mem_dq_oe  (mem_dq_oe)
   );

   sbs_rdpipe #(
      .DW(DW), .RD_LAT(RD_LAT)
   ) u_rdpipe (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_now   (iss_valid && !iss_write),
      .rd_word  (pin_rd_word),
      .dq_i     (mem_dq_i),
      .rd_valid (rd_valid),
      .rd_data  (rd_data),
      .oe       (mem_oe),
      .pend     (rd_pend)
   );

endmodule

// File: rtl/sbsram_burst_ctrl_chk.sv
module sbsram_burst_ctrl_chk #(
   parameter int AW     = 20,
   parameter int LW     = 8,
   parameter int RD_LAT = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_start,
   input logic [LW-1:0] req_len,
   input logic          busy,
   input logic          rd_valid,
   input logic          mem_cs,
   input logic          mem_astb,
   input logic [AW-1:0] mem_addr,
   input logic          mem_we,
   input logic          mem_oe,
   input logic          mem_dq_oe
);

   logic [RD_LAT:0] rd_dly;

   always_ff @(posedge clk) begin
      if (!rst_n) rd_dly <= '0;
      else        rd_dly <= {rd_dly[RD_LAT-1:0], mem_cs && !mem_we};
   end

   a_r8_oe_excl_we: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_oe && mem_we));

   a_r5_we_with_data: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_cs && mem_dq_oe));

   a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_cs && !mem_astb) |-> $stable(mem_addr));

   a_r3_first_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_cs && !$past(mem_cs)) |-> mem_astb);

   a_r7_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mem_cs && !mem_we) && !mem_cs) |-> mem_astb);

   a_r2_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
      (req_start && req_len == '0 && !busy) |=> !busy);

   a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid == rd_dly[RD_LAT]);

endmodule

bind sbsram_burst_ctrl sbsram_burst_ctrl_chk #(
   .AW(AW), .LW(LW), .RD_LAT(RD_LAT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_start (req_start),
   .req_len   (req_len),
   .busy      (busy),
   .rd_valid  (rd_valid),
   .mem_cs    (mem_cs),
   .mem_astb  (mem_astb),
   .mem_addr  (mem_addr),
   .mem_we    (mem_we),
   .mem_oe    (mem_oe),
   .mem_dq_oe (mem_dq_oe)
);

// File: tb/sbsram_burst_ctrl_tb.sv
module sbsram_burst_ctrl_tb;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 16;
   localparam int DW = 32;
   localparam int LW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_start = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [LW-1:0] req_len = '0;
   logic          req_write = 1'b0;
   logic [3:0]    req_be = 4'hF;
   logic          wr_req;
   logic [DW-1:0] wr_data = '0;
   logic [3:0]    wr_be = '0;
   logic          busy, rd_valid;
   logic [DW-1:0] rd_data;
   logic          mem_cs, mem_astb, mem_we, mem_oe, mem_dq_oe;
   logic [AW-1:0] mem_addr;
   logic [3:0]    mem_be;
   logic [DW-1:0] mem_dq_o;
   logic [DW-1:0] mem_dq_i = '0;

   sbsram_burst_ctrl #(.AW(AW), .DW(DW), .LW(LW)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_addr(req_addr),
      .req_len(req_len), .req_write(req_write), .req_be(req_be),
      .wr_req(wr_req), .wr_data(wr_data), .wr_be(wr_be), .busy(busy),
      .rd_valid(rd_valid), .rd_data(rd_data), .mem_cs(mem_cs),
      .mem_astb(mem_astb), .mem_addr(mem_addr), .mem_be(mem_be),
      .mem_we(mem_we), .mem_oe(mem_oe), .mem_dq_o(mem_dq_o),
      .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // ---------------- memory model with modulo-4 burst counter ----------------
   logic [DW-1:0] mdl    [0:255];
   logic [DW-1:0] shadow [0:255];
   logic [DW-1:0] stage_q = '0;
   int m_base = 0, m_cnt = 0;

   always @(posedge clk) begin
      int eff;
      cyc <= cyc + 1;
      eff = 0;
      if (mem_cs) begin
         if (mem_astb) begin m_base = int'(mem_addr); m_cnt = 0; end
         else m_cnt = m_cnt + 1;
         eff = ((m_base & ~3) | ((m_base + m_cnt) & 3)) & 255;
         if (mem_we)
            for (int b = 0; b < 4; b++)
               if (mem_be[b]) mdl[eff][8*b +: 8] = mem_dq_o[8*b +: 8];
      end
      mem_dq_i <= stage_q;
      stage_q  <= (mem_cs && !mem_we) ? mdl[eff] : 32'hDEAD_BEEF;
   end

   // ---------------- write data source ----------------
   logic [DW-1:0] wdat [0:63];
   logic [3:0]    wbe  [0:63];
   int wr_idx = 0;

   always @(negedge clk) begin
      if (wr_req) begin
         wr_data = wdat[wr_idx];
         wr_be   = wbe[wr_idx];
         wr_idx++;
      end
   end

   // ---------------- pin monitor ----------------
   int t_addr = 0, t_len = 0;
   logic [3:0] t_be = 4'hF;
   int words, astb_err, addr_err, wpin_err, rbe_err, rdat_err, oe_err, we_seen;
   int desel_cnt, desel_err, rv_idx, first_rd_cyc, first_rv_cyc, last_rv_cyc, busy_fall_cyc;
   int last_strobe = 0;
   bit prev_rdword = 0, prev_oe = 0, prev_busy = 0;

   task automatic clear_mon();
      words = 0; astb_err = 0; addr_err = 0; wpin_err = 0; rbe_err = 0;
      rdat_err = 0; oe_err = 0; we_seen = 0; desel_cnt = 0; desel_err = 0;
      rv_idx = 0; first_rd_cyc = -1; first_rv_cyc = -1; last_rv_cyc = -1;
      busy_fall_cyc = -1;
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_cs) begin
            int w;
            bit exp_astb;
            w = t_addr + words;
            exp_astb = (words == 0) || ((w & 3) == 0);
            if (mem_astb != exp_astb) astb_err++;
            if (exp_astb) last_strobe = w;
            if (int'(mem_addr) != last_strobe) addr_err++;
            if (mem_we) begin
               we_seen++;
               if (!mem_dq_oe || mem_dq_o != wdat[words] || mem_be != wbe[words]) wpin_err++;
            end else begin
               if (first_rd_cyc < 0) first_rd_cyc = cyc;
               if (mem_be != t_be) rbe_err++;
               if (!mem_oe) oe_err++;
            end
            words++;
         end
         if (prev_rdword && !mem_cs) begin
            desel_cnt++;
            if (!mem_astb) desel_err++;
         end
         if (mem_oe && mem_we) oe_err++;
         if (rd_valid) begin
            if (!prev_oe) oe_err++;
            if (rd_data != shadow[(t_addr + rv_idx) & 255]) rdat_err++;
            if (first_rv_cyc < 0) first_rv_cyc = cyc;
            last_rv_cyc = cyc;
            rv_idx++;
         end
         if (prev_busy && !busy) busy_fall_cyc = cyc;
         prev_rdword = mem_cs && !mem_we;
         prev_oe     = mem_oe;
         prev_busy   = busy;
      end
   end

   // ---------------- helpers ----------------
   task automatic pulse_start(input bit w, input int a, input int n, input logic [3:0] be);
      @(negedge clk);
      req_write = w; req_addr = AW'(a); req_len = LW'(n); req_be = be;
      req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
   endtask

   task automatic wait_idle();
      for (int k = 0; k < 300 && busy; k++) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic prep(input bit w, input int a, input int n, input logic [3:0] be);
      t_addr = a; t_len = n; t_be = be; wr_idx = 0;
      clear_mon();
      if (w) begin
         for (int i = 0; i < n; i++) begin
            wdat[i] = {8'(a) ^ 8'h5A, 8'(i), 8'(a + i), 8'(i * 7 + 3)};
            wbe[i]  = (i % 3 == 0) ? 4'hF : ((i % 3 == 1) ? 4'h3 : 4'hC);
            for (int b = 0; b < 4; b++)
               if (wbe[i][b]) shadow[(a + i) & 255][8*b +: 8] = wdat[i][8*b +: 8];
         end
      end
   endtask

   task automatic common_checks(input string nm);
      check(words == t_len, {nm, " R5 R6 word count"}, words, t_len);
      check(astb_err == 0, {nm, " R3 strobe pattern"}, astb_err, 0);
      check(addr_err == 0, {nm, " R4 address hold"}, addr_err, 0);
      check(oe_err == 0, {nm, " R8 output enable window"}, oe_err, 0);
   endtask

   task automatic do_write(input int a, input int n);
      prep(1'b1, a, n, 4'hF);
      pulse_start(1'b1, a, n, 4'hF);
      wait_idle();
      common_checks("write");
      check(wr_idx == n, "write R5 wr_req pulses", wr_idx, n);
      check(wpin_err == 0, "write R5 pin data/mask", wpin_err, 0);
      check(desel_cnt == 0, "write R7 no deselect", desel_cnt, 0);
   endtask

   task automatic do_read(input int a, input int n, input logic [3:0] be);
      prep(1'b0, a, n, be);
      pulse_start(1'b0, a, n, be);
      wait_idle();
      common_checks("read");
      check(rv_idx == n, "read R6 returned words", rv_idx, n);
      check(rdat_err == 0, "read R6 data order/value", rdat_err, 0);
      check(first_rv_cyc - first_rd_cyc == 3, "read R6 latency", first_rv_cyc - first_rd_cyc, 3);
      check(desel_cnt == 1 && desel_err == 0, "read R7 deselect cycle", desel_err, 0);
      check(busy_fall_cyc == last_rv_cyc, "read R9 busy falls with last word", busy_fall_cyc, last_rv_cyc);
      check(rbe_err == 0, "read R10 byte mask", rbe_err, 0);
      check(we_seen == 0, "read R8 no write enable", we_seen, 0);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      check(!mem_cs && !mem_astb && !mem_we && !mem_oe && !mem_dq_oe && !rd_valid && !busy,
            "R1 control outputs idle in reset", {mem_cs, mem_astb, mem_we, mem_oe, mem_dq_oe, rd_valid, busy}, 0);
      check(mem_be == 4'h0, "R1 byte enables clear", mem_be, 0);
   endtask

   task automatic t_zero_len();
      prep(1'b0, 8, 0, 4'hF);
      pulse_start(1'b0, 8, 0, 4'hF);
      check(busy == 1'b0, "R2 zero count not accepted", busy, 0);
      repeat (5) @(negedge clk);
      check(words == 0, "R2 no memory cycle", words, 0);
   endtask

   task automatic t_busy_ignore();
      prep(1'b0, 32, 4, 4'hF);
      pulse_start(1'b0, 32, 4, 4'hF);
      pulse_start(1'b1, 48, 3, 4'hF);
      wait_idle();
      check(words == 4, "R9 second start ignored (word count)", words, 4);
      check(we_seen == 0, "R9 second start ignored (no write)", we_seen, 0);
      check(rdat_err == 0 && rv_idx == 4, "R9 first read intact", rdat_err, 0);
   endtask

   // ---------------- main ----------------
   initial begin
      for (int i = 0; i < 256; i++) begin
         mdl[i]    = 32'hA5000000 | i;
         shadow[i] = 32'hA5000000 | i;
      end
      clear_mon();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_zero_len();
      do_write(2, 6);
      do_read(2, 6, 4'hF);
      do_write(7, 2);
      do_read(7, 2, 4'hF);
      do_write(16'h15, 11);
      do_read(16'h15, 11, 4'h5);
      do_read(4, 1, 4'h9);
      do_read(0, 9, 4'hF);
      t_busy_ignore();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule